// File: doc/BRIEF.md
# E3 Loss-of-Signal Defect Monitor

This block watches the recovered E3 receive bit stream, one bit for each cycle in which `bit_en` is high, together with the loss-of-signal flag from the line interface. It declares a framer-level loss-of-signal (LOS) defect and later clears it. The defect state is shown in a status register. Every change of the defect state is latched into an interrupt status register that clears when it is read. That register drives an active-low interrupt pin through a per-bit enable mask.

The block declares LOS in either of two cases: the line interface reports LOS, or the count of consecutive received zeros reaches a programmable threshold. While LOS is declared, the block counts received bits in a clean window. Any run of four zeros restarts that window. The defect clears only when the window has reached 32 bits and the line interface no longer reports LOS. The other defect flags are plain inputs and are only shown in the status register. A byte-wide register port gives read access and a few write fields.

Top module: `e3_los_monitor`

## Requirements
- R1: LOS is declared (`los_defect` rises on the next clock edge) when `liu_los` is high, or on a `bit_en` cycle whose zero bit makes the run of consecutive zeros reach `ZERO_THR` (default 32). The run counts zeros on `bit_en` cycles only and is reset by any one.
- R2: While LOS is declared, the clean window counts `bit_en` bits received since the declaration. It restarts from zero at every bit that completes or extends a run of four or more zeros counted since the declaration. Clearing happens only on a `bit_en` cycle that brings the window to 32 bits.
- R3: LOS is never cleared while `liu_los` is high, however long the clean window has been.
- R4: Address 0x1111 reads {bit7 LOF algorithm select, bit6 LOF in, bit5 OOF in, bit4 LOS defect, bit3 AIS in, bit2 payload-unstable in, bit1 trail-mark in, bit0 FERF in}. Only bit 7 is writable, and it drives `lof_algo_sel`.
- R5: Address 0x1114 reads the pending interrupt flags. Bit 1 is set by both the declare edge and the clear edge of LOS. Bits 0, 2, 3, 4, 5 and 6 are set by `other_evt[0]` to `other_evt[5]` in that order. Bit 7 reads 0.
- R6: A read of 0x1114 returns the current flags, and the flags clear at that clock edge. An event in the same cycle as the read stays pending.
- R7: Address 0x1117 holds the interrupt enables in bits 6:0 and resets to 0x7F. `int_n` is low exactly when some pending flag has its enable set.
- R8: After a synchronous reset, LOS is not declared, no flags are pending, `int_n` is high and `lof_algo_sel` is 0.
- R9: Writes to read-only bits, to 0x1114 or to any unmapped address change nothing. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Receive bit valid |
| rx_bit | input | 1 | Received E3 bit |
| liu_los | input | 1 | Line-interface LOS flag |
| lof_in | input | 1 | LOF defect flag for status |
| oof_in | input | 1 | OOF defect flag for status |
| ais_in | input | 1 | AIS defect flag for status |
| pld_unstab_in | input | 1 | Payload-unstable flag for status |
| tmark_in | input | 1 | Trail-mark flag for status |
| ferf_in | input | 1 | FERF defect flag for status |
| other_evt | input | 6 | Other change events for the interrupt flags |
| reg_addr | input | AW | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| los_defect | output | 1 | LOS defect state |
| lof_algo_sel | output | 1 | LOF algorithm select field |
| int_n | output | 1 | Interrupt pin, active low |

## Verification
Declare, clear, the flag updates, the read-to-clear and register writes all take effect on the clock edge that samples the causing input. So `los_defect`, `int_n` and `lof_algo_sel` reflect a stimulus one edge later. `reg_rdata` is combinational and valid in the same cycle as its strobe. The bench drives inputs just after each falling edge and updates its behavioural model on the rising edge. It compares the outputs at the next falling edge, and it checks read data a moment after driving the strobe, so every comparison falls one edge after its cause.

// File: rtl/e3_los_monitor.sv
module e3_los_monitor #(
  parameter int ZERO_THR = 32,
  parameter int WIN = 32,
  parameter int RUN = 4,
  parameter int AW = 16,
  parameter logic [AW-1:0] STAT_ADDR = 16'h1111,
  parameter logic [AW-1:0] ISR_ADDR = 16'h1114,
  parameter logic [AW-1:0] IER_ADDR = 16'h1117
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          rx_bit,
  input  logic          liu_los,
  input  logic          lof_in,
  input  logic          oof_in,
  input  logic          ais_in,
  input  logic          pld_unstab_in,
  input  logic          tmark_in,
  input  logic          ferf_in,
  input  logic [5:0]    other_evt,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          los_defect,
  output logic          lof_algo_sel,
  output logic          int_n
);
  localparam int ZW = $clog2(ZERO_THR + 1);
  localparam int WW = $clog2(WIN + 1);
  localparam int QW = $clog2(RUN + 1);

  logic [ZW-1:0] zrun;
  logic [WW-1:0] win;
  logic [QW-1:0] qrun;
  logic          los_q, algo_q;
  logic [6:0]    isr_q, ier_q;

  wire [ZW-1:0] zrun_nx = !bit_en ? zrun :
                          rx_bit ? '0 :
                          (zrun == ZW'(ZERO_THR)) ? zrun : zrun + 1'b1;
  wire [QW-1:0] qrun_nx = rx_bit ? '0 : (qrun == QW'(RUN)) ? qrun : qrun + 1'b1;
  wire [WW-1:0] win_nx  = (qrun_nx == QW'(RUN)) ? '0 :
                          (win == WW'(WIN)) ? win : win + 1'b1;

  wire declare = ~los_q & (liu_los | (bit_en & ~rx_bit & (zrun_nx == ZW'(ZERO_THR))));
  wire clear   = los_q & bit_en & ~liu_los & (win_nx == WW'(WIN));
  wire los_chg = declare | clear;
  wire isr_rd  = reg_rd && (reg_addr == ISR_ADDR);
  wire [6:0] evt = {other_evt[5:1], los_chg, other_evt[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      zrun   <= '0;
      win    <= '0;
      qrun   <= '0;
      los_q  <= 1'b0;
      algo_q <= 1'b0;
      isr_q  <= '0;
      ier_q  <= 7'h7F;
    end else begin
      zrun <= zrun_nx;
      if (declare || clear) begin
        los_q <= declare;
        win   <= '0;
        qrun  <= '0;
      end else if (los_q && bit_en) begin
        win  <= win_nx;
        qrun <= qrun_nx;
      end
      isr_q <= (isr_rd ? 7'h00 : isr_q) | evt;
      if (reg_wr && reg_addr == STAT_ADDR) algo_q <= reg_wdata[7];
      if (reg_wr && reg_addr == IER_ADDR)  ier_q  <= reg_wdata[6:0];
    end
  end

  always_comb begin
    case (reg_addr)
      STAT_ADDR: reg_rdata = {algo_q, lof_in, oof_in, los_q, ais_in, pld_unstab_in, tmark_in, ferf_in};
      ISR_ADDR:  reg_rdata = {1'b0, isr_q};
      IER_ADDR:  reg_rdata = {1'b0, ier_q};
      default:   reg_rdata = 8'h00;
    endcase
  end

  assign los_defect   = los_q;
  assign lof_algo_sel = algo_q;
  assign int_n        = ~|(isr_q & ier_q);

  p_declare_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(los_q) |-> ($past(liu_los) || ($past(bit_en) && !$past(rx_bit))));
  p_clear_window_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(los_q) |-> ($past(bit_en) && $past(win) >= WW'(WIN - 1)));
  p_clear_liu_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(los_q) |-> !$past(liu_los));
  p_change_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (los_q != $past(los_q)) |-> isr_q[1]);
  p_read_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (isr_rd && !los_chg) |=> !isr_q[1]);
endmodule

// File: tb/tb_e3_los_monitor.sv
module tb_e3_los_monitor;
  localparam logic [15:0] A_STAT = 16'h1111, A_ISR = 16'h1114, A_IER = 16'h1117;
  logic clk = 0, rst = 1;
  logic bit_en = 0, rx_bit = 1, liu_los = 0;
  logic [5:0] stat_in = 6'b0;
  logic [5:0] other_evt = 0;
  logic [15:0] reg_addr = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic los_defect, lof_algo_sel, int_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  e3_los_monitor dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .liu_los(liu_los),
    .lof_in(stat_in[5]), .oof_in(stat_in[4]), .ais_in(stat_in[3]),
    .pld_unstab_in(stat_in[2]), .tmark_in(stat_in[1]), .ferf_in(stat_in[0]),
    .other_evt(other_evt), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .los_defect(los_defect),
    .lof_algo_sel(lof_algo_sel), .int_n(int_n));

  // behavioural reference
  bit m_los, m_algo;
  bit [6:0] m_isr, m_ier;
  int m_zrun, m_cnt;
  bit hist[$];

  function automatic bit win_clean();
    int run = 0, last = -1;
    if (m_cnt < 32) return 0;
    for (int i = 0; i < hist.size(); i++) begin
      run = hist[i] ? 0 : run + 1;
      if (run >= 4) last = i;
    end
    return (hist.size() - 1 - last) >= 32;
  endfunction

  function automatic logic [7:0] m_read(logic [15:0] a);
    case (a)
      A_STAT: return {m_algo, stat_in[5:4], m_los, stat_in[3:0]};
      A_ISR:  return {1'b0, m_isr};
      A_IER:  return {1'b0, m_ier};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    bit chg;
    chg = 0;
    if (rst) begin
      m_los = 0; m_algo = 0; m_isr = 0; m_ier = 7'h7F; m_zrun = 0; m_cnt = 0;
      hist.delete();
    end else begin
      if (bit_en) m_zrun = rx_bit ? 0 : m_zrun + 1;
      if (!m_los) begin
        if (liu_los || (bit_en && !rx_bit && m_zrun >= 32)) begin
          m_los = 1; chg = 1; m_cnt = 0; hist.delete();
        end
      end else if (bit_en) begin
        hist.push_back(rx_bit);
        m_cnt++;
        if (hist.size() > 40) void'(hist.pop_front());
        if (win_clean() && !liu_los) begin m_los = 0; chg = 1; end
      end
      m_isr = ((reg_rd && reg_addr == A_ISR) ? 7'h00 : m_isr) |
              {other_evt[5:1], chg, other_evt[0]};
      if (reg_wr && reg_addr == A_STAT) m_algo = reg_wdata[7];
      if (reg_wr && reg_addr == A_IER) m_ier = reg_wdata[6:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: compare outputs at falling edge, then drive
  task automatic cyc(input bit be, input bit b, input bit liu,
                     input bit rd = 0, input bit wr = 0,
                     input logic [15:0] a = 0, input logic [7:0] wd = 0,
                     input logic [5:0] ev = 0);
    @(negedge clk);
    chk(los_defect === m_los, m_los ? "R1 los_defect" : "R2 los_defect", los_defect, m_los);
    chk(int_n === ~|(m_isr & m_ier), "R7 int_n", int_n, ~|(m_isr & m_ier));
    chk(lof_algo_sel === m_algo, "R4 lof_algo_sel", lof_algo_sel, m_algo);
    bit_en = be; rx_bit = b; liu_los = liu; reg_rd = rd; reg_wr = wr;
    reg_addr = a; reg_wdata = wd; other_evt = ev;
    #1;
    if (rd) chk(reg_rdata === m_read(a),
                (a == A_STAT) ? "R4 status read" : (a == A_ISR) ? "R5 flag read" :
                (a == A_IER) ? "R7 enable read" : "R9 unmapped read",
                reg_rdata, m_read(a));
  endtask

  task automatic bits(input int n, input logic [31:0] pat, input int plen, input bit liu = 0);
    for (int i = 0; i < n; i++) cyc(1, pat[i % plen], liu);
  endtask

  task automatic rd(input logic [15:0] a);
    cyc(0, 1, liu_los, 1, 0, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R8: reset state
    @(negedge clk);
    chk(los_defect === 0 && int_n === 1 && lof_algo_sel === 0, "R8 reset outputs",
        {los_defect, int_n, lof_algo_sel}, 3'b010);
    rd(A_ISR); rd(A_IER); rd(A_STAT);

    // R1 via line flag, R3 hold while flag stays high
    cyc(0, 1, 1); cyc(0, 1, 1);
    bits(40, 32'h1, 1, 1);
    @(negedge clk);
    chk(los_defect === 1, "R3 held by line flag", los_defect, 1);
    stat_in = 6'b101010;
    rd(A_STAT);
    bits(1, 32'h1, 1, 0);
    bits(2, 32'h1, 1, 0);
    rd(A_ISR);
    @(negedge clk);
    chk(int_n === 1, "R6 pin released after read", int_n, 1);
    rd(A_ISR);

    // R1 zero threshold: 31 zeros do not declare, 32 do
    bits(31, 32'h0, 1); bits(1, 32'h1, 1);
    chk(los_defect === 0, "R1 31 zeros no declare", los_defect, 0);
    bits(32, 32'h0, 1);
    // R2 window with runs of three zeros clears after 32 bits
    bits(40, 32'h8, 4);
    rd(A_ISR);
    // declare again, then a four-zero run restarts the window
    bits(33, 32'h0, 1);
    bits(20, 32'h1, 1); bits(4, 32'h0, 1); bits(40, 32'h1, 1);
    // gaps in bit_en
    cyc(0, 1, 1);
    for (int i = 0; i < 80; i++) cyc(i % 3 == 0, 1, 0);

    // R7 masking
    cyc(0, 1, 0, 0, 1, A_IER, 8'h00);
    cyc(0, 1, 1); bits(40, 32'h1, 1);
    rd(A_IER);
    cyc(0, 1, 0, 0, 1, A_IER, 8'hFD);
    cyc(0, 1, 0, 0, 1, A_IER, 8'h02);
    rd(A_ISR);

    // R6 event coinciding with read stays pending
    cyc(0, 1, 0, 0, 0, 0, 0, 6'b111111);
    cyc(0, 1, 0, 1, 0, A_ISR, 0, 6'b000001);
    rd(A_ISR);
    cyc(0, 1, 0, 1, 0, A_ISR, 0, 6'b000000);
    cyc(0, 1, 0, 0, 1, A_IER, 8'h7F);

    // R4 algo write, R9 ignored writes
    cyc(0, 1, 0, 0, 1, A_STAT, 8'hFF);
    rd(A_STAT);
    cyc(0, 1, 0, 0, 1, A_ISR, 8'hFF);
    cyc(0, 1, 0, 0, 1, 16'h1200, 8'hFF);
    rd(A_ISR); rd(16'h1200);
    cyc(0, 1, 0, 0, 1, A_STAT, 8'h00);
    rd(A_STAT);

    // mixed traffic
    for (int i = 0; i < 6000; i++) begin
      automatic int r = $urandom % 100;
      automatic bit b = ($urandom % 8) < (i % 2000 < 600 ? 1 : 5);
      automatic bit liu = (i % 1500) < 40;
      stat_in = 6'($urandom);
      if (r < 5)      cyc(1, b, liu, 1, 0, A_ISR, 0, 6'($urandom % 64) & 6'h21);
      else if (r < 7) cyc(1, b, liu, 1, 0, A_STAT);
      else if (r < 8) cyc(1, b, liu, 0, 1, A_IER, 8'($urandom));
      else            cyc(r < 85, b, liu);
    end
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule